// File: doc/BRIEF.md
# Block transfer length sequencer

This block follows the data phase of a card command. A size register holds a 4-bit code n, and a data block then carries 2^n data bytes. Start bits, start bytes and CRC are not counted. A 16-bit block count register says how many blocks a multiblock command moves. The data path pulses a strobe for each data byte. At the last byte of every block the sequencer pulses end-of-block, which tells the data path to append its CRC. In a multiblock command the count register steps down once per finished block.

When the last block ends, the sequencer pulses command-done and sets a sticky interrupt flag. A stream command does not use the size register. It runs until a stop strobe arrives. The same stop strobe cuts a block command short without raising the interrupt. Software sets up and reads back the registers through a small synchronous register port.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the size code, the block count, the interrupt, busy, end-of-block and command-done are all zero.
- R2: Size code n (0 to 11) gives 2^n data bytes per block. end_blk is high for exactly one cycle, the cycle after the 2^n-th byte strobe of that block.
- R3: A size code with its two top bits 11 (12 to 15) drives size_err high and shows in bit 1 of register 2. A non-stream start with such a code is refused: busy stays low and no pulse follows.
- R4: In a multiblock command every block uses the full size. The count register (address 1) drops by one in the cycle after each block's last byte.
- R5: When the count reaches zero the command ends. In that same cycle cmd_done pulses for one cycle, the interrupt sets, busy clears and the last end_blk pulse is seen.
- R6: A single-block command (multi flag low) ends after one block whatever the count register holds, and leaves that count unchanged. It gives cmd_done and the interrupt.
- R7: The interrupt (bit 0 of register 2) stays set until a write to address 2 with data bit 0 set. Writing 0 there leaves it set. A set in the same cycle as a clear wins.
- R8: A stream start (stream flag high) ignores the size code, even a reserved one. It gives no end_blk and ends only on stop_stb, with a cmd_done pulse and no interrupt.
- R9: stop_stb during a block command aborts it. Busy clears, there is no cmd_done and no interrupt, and the count keeps its partly decremented value.
- R10: Register 0 reads the size code in bits 3:0 and zero in bits 15:4. Writes to bits 15:4 have no effect.
- R11: A multiblock start with a count of zero ends at once. cmd_done pulses and the interrupt sets in the next cycle, with no end_blk.
- R12: While busy (register 2 bit 2), writes to the size and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 size, 1 block count, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Readback of the selected register |
| cmd_start | input | 1 | Command start strobe, taken only when idle |
| cmd_multi | input | 1 | Start qualifier: multiblock command |
| cmd_stream | input | 1 | Start qualifier: stream command (wins over multi) |
| byte_stb | input | 1 | One data byte moved |
| stop_stb | input | 1 | Stop: ends a stream, aborts a block command |
| end_blk | output | 1 | One-cycle pulse after a block's last byte |
| cmd_done | output | 1 | One-cycle pulse on normal command end |
| irq | output | 1 | Sticky interrupt flag |
| busy | output | 1 | A command is running |
| size_err | output | 1 | Size register holds a reserved code |

## Verification
Each strobe is sampled on a rising edge. end_blk, cmd_done, irq, busy and the count readback all change at that edge, so they are due one cycle after the strobe. size_err and the size readback follow the register in the cycle after its write edge. The bench changes inputs just after a falling edge and samples each result at the next falling edge. It adds up pulses cycle by cycle, so a pulse in the wrong cycle or of the wrong length changes the totals it compares.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int CNT_W    = 16,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 11,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmd_start,
  input  logic              cmd_multi,
  input  logic              cmd_stream,
  input  logic              byte_stb,
  input  logic              stop_stb,
  output logic              end_blk,
  output logic              cmd_done,
  output logic              irq,
  output logic              busy,
  output logic              size_err
);
  localparam int BYTE_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  typedef enum logic [1:0] {IDLE, BLK, STRM} mode_t;

  mode_t             mode;
  logic [CODE_W-1:0] size_code;
  logic [CNT_W-1:0]  blk_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic              is_multi;

  wire               wr_size  = reg_wr && reg_addr == 2'd0 && mode == IDLE;
  wire               wr_cnt   = reg_wr && reg_addr == 2'd1 && mode == IDLE;
  wire               irq_clr  = reg_wr && reg_addr == 2'd2 && reg_wdata[0];
  wire [BYTE_W-1:0]  last_idx = ~({BYTE_W{1'b1}} << size_code);
  wire               blk_last = byte_stb && byte_cnt == last_idx;

  assign size_err = size_code > CODE_W'(MAX_CODE);
  assign busy     = mode != IDLE;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DATA_W'(size_code);
      2'd1:    reg_rdata = DATA_W'(blk_cnt);
      2'd2:    reg_rdata = DATA_W'({busy, size_err, irq});
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= IDLE;
      size_code <= '0;
      blk_cnt   <= '0;
      byte_cnt  <= '0;
      is_multi  <= 1'b0;
      end_blk   <= 1'b0;
      cmd_done  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      end_blk  <= 1'b0;
      cmd_done <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      if (wr_size) size_code <= reg_wdata[CODE_W-1:0];
      if (wr_cnt)  blk_cnt   <= reg_wdata[CNT_W-1:0];
      case (mode)
        IDLE: if (cmd_start) begin
          if (cmd_stream) begin
            mode <= STRM;
          end else if (!size_err) begin
            if (cmd_multi && blk_cnt == '0) begin
              cmd_done <= 1'b1;
              irq      <= 1'b1;
            end else begin
              mode     <= BLK;
              is_multi <= cmd_multi;
              byte_cnt <= '0;
            end
          end
        end
        BLK: if (stop_stb) begin
          mode <= IDLE;
        end else if (byte_stb) begin
          if (blk_last) begin
            byte_cnt <= '0;
            end_blk  <= 1'b1;
            if (is_multi) blk_cnt <= blk_cnt - CNT_W'(1);
            if (!is_multi || blk_cnt == CNT_W'(1)) begin
              mode     <= IDLE;
              cmd_done <= 1'b1;
              irq      <= 1'b1;
            end
          end else begin
            byte_cnt <= byte_cnt + BYTE_W'(1);
          end
        end
        STRM: if (stop_stb) begin
          mode     <= IDLE;
          cmd_done <= 1'b1;
        end
        default: mode <= IDLE;
      endcase
    end
  end

  AST_BLKEND_ONLY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    end_blk |-> $past(mode == BLK)); // R8
  AST_RESERVED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDLE && cmd_start && !cmd_stream && size_err) |=> (mode == IDLE && !cmd_done)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BLK && is_multi && blk_last && !stop_stb) |=> (blk_cnt == $past(blk_cnt) - CNT_W'(1))); // R4
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cmd_done); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BLK && stop_stb) |=> (!cmd_done && !end_blk && mode == IDLE)); // R9
  AST_SIZE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != IDLE) |=> $stable(size_code)); // R12
endmodule

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cmd_start = 1'b0, cmd_multi = 1'b0, cmd_stream = 1'b0;
  logic        byte_stb = 1'b0, stop_stb = 1'b0;
  logic        end_blk, cmd_done, irq, busy, size_err;

  int n_chk = 0, n_err = 0, nb = 0, nd = 0;

  always #2.5 clk = ~clk;

  blk_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_start(cmd_start),
    .cmd_multi(cmd_multi), .cmd_stream(cmd_stream), .byte_stb(byte_stb),
    .stop_stb(stop_stb), .end_blk(end_blk), .cmd_done(cmd_done), .irq(irq),
    .busy(busy), .size_err(size_err)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic [15:0] cnt;
    logic        multi;
    logic        stream;
    logic        stop;
    logic [11:0] nbytes;
    logic [3:0]  eblk;
    logic        edone;
    logic        eirq;
    logic [15:0] ecnt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  16'd3, 1'b1, 1'b0, 1'b0, 12'd3,    4'd3, 1'b1, 1'b1, 16'd0}, // R2 R4 R5
    '{4'd2,  16'd2, 1'b1, 1'b0, 1'b0, 12'd8,    4'd2, 1'b1, 1'b1, 16'd0}, // R4
    '{4'd3,  16'd7, 1'b0, 1'b0, 1'b0, 12'd8,    4'd1, 1'b1, 1'b1, 16'd7}, // R6
    '{4'd1,  16'd4, 1'b1, 1'b0, 1'b1, 12'd5,    4'd2, 1'b0, 1'b0, 16'd2}, // R9
    '{4'd12, 16'd9, 1'b0, 1'b1, 1'b1, 12'd10,   4'd0, 1'b1, 1'b0, 16'd9}, // R8
    '{4'd13, 16'd1, 1'b0, 1'b0, 1'b0, 12'd4,    4'd0, 1'b0, 1'b0, 16'd1}, // R3
    '{4'd0,  16'd0, 1'b1, 1'b0, 1'b0, 12'd0,    4'd0, 1'b1, 1'b1, 16'd0}, // R11
    '{4'd9,  16'd0, 1'b0, 1'b0, 1'b0, 12'd512,  4'd1, 1'b1, 1'b1, 16'd0}, // R2
    '{4'd11, 16'd1, 1'b1, 1'b0, 1'b0, 12'd2048, 4'd1, 1'b1, 1'b1, 16'd0}, // R2
    '{4'd4,  16'd2, 1'b1, 1'b0, 1'b1, 12'd20,   4'd1, 1'b0, 1'b0, 16'd1}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (end_blk) nb++;
    if (cmd_done) nd++;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1 d = reg_rdata;
  endtask

  task automatic start(input logic m, input logic s);
    cmd_start = 1'b1; cmd_multi = m; cmd_stream = s;
    step();
    cmd_start = 1'b0; cmd_multi = 1'b0; cmd_stream = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 end_blk", end_blk, 0);
    chk("R1 cmd_done", cmd_done, 0);
    rreg(2'd0, rd); chk("R1 size reg", rd, 0);
    rreg(2'd1, rd); chk("R1 count reg", rd, 0);
    rreg(2'd2, rd); chk("R1 status reg", rd, 0);

    // R10 upper bits of the size register
    wreg(2'd0, 16'hFFF5);
    rreg(2'd0, rd); chk("R10 size readback", rd, 16'h0005);

    // R3 reserved code flag
    wreg(2'd0, 16'h000C);
    chk("R3 size_err", size_err, 1);
    rreg(2'd2, rd); chk("R3 status bit1", rd[1], 1);

    for (int i = 0; i < NV; i++) begin
      wreg(2'd0, {12'd0, VEC[i].code});
      wreg(2'd1, VEC[i].cnt);
      wreg(2'd2, 16'h0001);
      nb = 0; nd = 0;
      start(VEC[i].multi, VEC[i].stream);
      for (int b = 0; b < int'(VEC[i].nbytes); b++) begin
        byte_stb = 1'b1; step();
      end
      byte_stb = 1'b0;
      if (VEC[i].stop) begin
        stop_stb = 1'b1; step(); stop_stb = 1'b0;
      end
      step();
      chk($sformatf("vec%0d R2/R4 block ends", i), nb, VEC[i].eblk);
      chk($sformatf("vec%0d R5/R8/R9 done pulses", i), nd, VEC[i].edone);
      chk($sformatf("vec%0d R5/R7 irq", i), irq, VEC[i].eirq);
      rreg(2'd1, rd); chk($sformatf("vec%0d R4/R6 count", i), rd, VEC[i].ecnt);
      chk($sformatf("vec%0d R3/R9 busy", i), busy, 0);
    end

    // R2 and R5 cycle exactness: code 1, single block
    wreg(2'd0, 16'h0001);
    wreg(2'd2, 16'h0001);
    start(1'b0, 1'b0);
    chk("R12 busy after start", busy, 1);
    byte_stb = 1'b1; step();
    chk("R2 no end after first byte", end_blk, 0);
    step(); byte_stb = 1'b0;
    chk("R2 end after second byte", end_blk, 1);
    chk("R5 done same cycle", cmd_done, 1);
    chk("R5 busy clear same cycle", busy, 0);
    chk("R5 irq set same cycle", irq, 1);
    step();
    chk("R2 end is one cycle", end_blk, 0);
    chk("R5 done is one cycle", cmd_done, 0);

    // R7 sticky interrupt, write 0 keeps it, write 1 clears it
    wreg(2'd2, 16'h0000);
    chk("R7 irq kept on write 0", irq, 1);
    wreg(2'd2, 16'h0001);
    chk("R7 irq cleared on write 1", irq, 0);

    // R7 set wins over clear in the same cycle
    wreg(2'd0, 16'h0000);
    start(1'b0, 1'b0);
    byte_stb = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0001;
    step();
    byte_stb = 1'b0; reg_wr = 1'b0;
    chk("R7 set wins over clear", irq, 1);

    // R12 writes ignored while busy
    wreg(2'd0, 16'h0001);
    wreg(2'd1, 16'd3);
    nb = 0; nd = 0;
    start(1'b1, 1'b0);
    wreg(2'd1, 16'd9);
    wreg(2'd0, 16'h0005);
    rreg(2'd1, rd); chk("R12 count kept while busy", rd, 3);
    rreg(2'd0, rd); chk("R12 size kept while busy", rd, 1);
    for (int b = 0; b < 6; b++) begin
      byte_stb = 1'b1; step();
    end
    byte_stb = 1'b0;
    step();
    chk("R12 block ends with old size", nb, 3);
    chk("R12 done once", nd, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule